// File: doc/BRIEF.md
# Command List Register Walker

This block executes command lists held in memory by turning them into masked writes on an internal register file. Software configures a list with a start-address register and a size register, then writes a nonzero value to the matching trigger register. The walker fetches 32-bit words one at a time through a simple read port. It decodes each header and applies the data words that follow it as register writes, each under a byte-lane mask. It moves from header to header until the configured byte count has been consumed.

There are two independent list slots, each with its own address, size and trigger registers. A list may itself write a trigger register. That write drops the rest of the running list and restarts fetching from the newly selected slot, which lets lists chain or jump. The register file is a plain array of masked-write words. A host write port reaches it through a fixed byte-address window, and a read tap exposes any entry.

Top module: `cmdlist_proc`

## Requirements
- R1: A header word is decoded as: target register ID in bits 15:0, byte-lane mask code in bits 19:16, extra word count in bits 27:20, and a step flag in bit 31.
- R2: A header is followed by (extra count + 1) data words, each producing one register write. With the step flag set, the target ID rises by one after every write. With the flag clear, every write goes to the header's ID.
- R3: Each write stores (old & ~m) | (data & m). Bit k of the mask code sets byte k (bits 8k+7:8k) of m.
- R4: When a command's total word count (header included) is odd, the one word after it is skipped without being read, so the next header is 8-byte aligned.
- R5: A nonzero write to register 20 (slot 0) or 21 (slot 1) starts a list. Its byte address is register 16 or 17, bits 27:0, shifted left by 3. Its byte size is register 18 or 19, bits 19:0, shifted left by 3. A zero write, or a zero size, starts nothing.
- R6: busy_o is low after reset and while idle. It stays high while a list is walked and falls once the consumed byte count reaches the size. Words past the size are never executed.
- R7: A nonzero write to register 20 or 21 made by the list itself abandons the rest of the running list and restarts at the slot it selects.
- R8: Host writes are accepted only at byte addresses 0x1EF01000 up to (but not including) 0x1EF01C00, at index (address − 0x1EF01000)/4, and only for indices below NUM_REGS. Every other host write changes nothing. All registers reset to zero.
- R9: Host writes are ignored while busy_o is high.
- R10: The read port keeps at most one read outstanding and reads each header and data word exactly once. Skipped padding words are not read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | 32 | Host byte address |
| host_wdata_i | input | 32 | Host write data |
| rd_idx_i | input | IDX_W | Register read tap index |
| rd_data_o | output | 32 | Register read tap data |
| mem_rd_o | output | 1 | Memory read request, one cycle per word |
| mem_addr_o | output | 32 | Memory byte address |
| mem_rdata_i | input | 32 | Memory read data |
| mem_rvalid_i | input | 1 | Memory read data valid |
| busy_o | output | 1 | List walk in progress |

## Verification
A list mixing a single-write command, a stepping three-write command and an odd-length fixed-target command shows apart the ID step, the fixed target, padding and the size stop. A misplaced pad or a missed size limit would execute planted headers that must never run. All 16 mask codes are swept on a preloaded register, so any lane-order or lane-select error shows in the result. A self-retriggering list, a zero trigger, host writes during a walk and host addresses just outside the window or past the last index cover the redirect and the ignore cases.

// File: rtl/cmdlist_pkg.sv
package cmdlist_pkg;
  localparam int unsigned REG_ADDR0 = 16;
  localparam int unsigned REG_ADDR1 = 17;
  localparam int unsigned REG_SIZE0 = 18;
  localparam int unsigned REG_SIZE1 = 19;
  localparam int unsigned REG_TRIG0 = 20;
  localparam int unsigned REG_TRIG1 = 21;
  localparam logic [31:0] WIN_BASE = 32'h1EF0_1000;
  localparam logic [31:0] WIN_SPAN = 32'h0000_0C00;

  typedef enum logic [2:0] {
    W_IDLE, W_HDR, W_HDR_WAIT, W_DAT, W_DAT_WAIT
  } walk_state_e;

  function automatic logic [31:0] lane_mask(input logic [3:0] code);
    logic [31:0] m;
    for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{code[k]}};
    return m;
  endfunction
endpackage

// File: rtl/cmd_host_window.sv
module cmd_host_window #(
  parameter int unsigned NUM_REGS = 64,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  logic             we_i,
  input  logic [31:0]      addr_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  import cmdlist_pkg::*;
  logic [31:0] off;
  logic        in_win;
  logic        unused_low;

  assign off        = addr_i - WIN_BASE;
  assign in_win     = (addr_i >= WIN_BASE) && (addr_i < WIN_BASE + WIN_SPAN);
  assign hit_o      = we_i && in_win && ({2'b00, off[31:2]} < NUM_REGS);
  assign idx_o      = off[IDX_W+1:2];
  assign unused_low = ^{off[1:0], off[31:IDX_W+2]};
endmodule

// File: rtl/cmd_regfile.sv
module cmd_regfile #(
  parameter int unsigned NUM_REGS = 64,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [IDX_W-1:0]           wr_idx_i,
  input  logic [31:0]                wr_data_i,
  input  logic [31:0]                wr_mask_i,
  output logic [NUM_REGS-1:0][31:0]  regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_o[g] <= '0;
      else if (wr_en_i && (wr_idx_i == IDX_W'(g)))
        regs_o[g] <= (regs_o[g] & ~wr_mask_i) | (wr_data_i & wr_mask_i);
    end
  end
endmodule

// File: rtl/cmd_walker.sv
module cmd_walker (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [31:0] start_base_i,
  input  logic [31:0] start_size_i,
  output logic        mem_rd_o,
  output logic [31:0] mem_addr_o,
  input  logic [31:0] mem_rdata_i,
  input  logic        mem_rvalid_i,
  output logic        wr_en_o,
  output logic [15:0] wr_id_o,
  output logic [31:0] wr_data_o,
  output logic [31:0] wr_mask_o,
  output logic        busy_o
);
  import cmdlist_pkg::*;
  walk_state_e state_q;
  logic [31:0] ptr_q, end_q, next_ptr;
  logic [15:0] id_q;
  logic [3:0]  code_q;
  logic [8:0]  left_q;
  logic        step_q, pad_q;
  logic        unused_hdr;

  assign unused_hdr = ^mem_rdata_i[30:28];
  assign mem_rd_o   = (state_q == W_HDR) || (state_q == W_DAT);
  assign mem_addr_o = ptr_q;
  assign busy_o     = (state_q != W_IDLE);
  assign wr_en_o    = (state_q == W_DAT_WAIT) && mem_rvalid_i;
  assign wr_id_o    = id_q;
  assign wr_data_o  = mem_rdata_i;
  assign wr_mask_o  = lane_mask(code_q);
  // skip one word after an odd-length command
  assign next_ptr   = ptr_q + (pad_q ? 32'd8 : 32'd4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= W_IDLE;
      ptr_q   <= '0;
      end_q   <= '0;
      id_q    <= '0;
      code_q  <= '0;
      left_q  <= '0;
      step_q  <= 1'b0;
      pad_q   <= 1'b0;
    end else if (start_i) begin
      ptr_q   <= start_base_i;
      end_q   <= start_base_i + start_size_i;
      state_q <= (start_size_i == '0) ? W_IDLE : W_HDR;
    end else begin
      unique case (state_q)
        W_IDLE: ;
        W_HDR:  state_q <= W_HDR_WAIT;
        W_DAT:  state_q <= W_DAT_WAIT;
        W_HDR_WAIT: if (mem_rvalid_i) begin
          id_q    <= mem_rdata_i[15:0];
          code_q  <= mem_rdata_i[19:16];
          left_q  <= {1'b0, mem_rdata_i[27:20]} + 9'd1;
          pad_q   <= mem_rdata_i[20];
          step_q  <= mem_rdata_i[31];
          ptr_q   <= ptr_q + 32'd4;
          state_q <= W_DAT;
        end
        W_DAT_WAIT: if (mem_rvalid_i) begin
          id_q   <= id_q + {15'd0, step_q};
          left_q <= left_q - 9'd1;
          if (left_q == 9'd1) begin
            ptr_q   <= next_ptr;
            state_q <= (next_ptr >= end_q) ? W_IDLE : W_HDR;
          end else begin
            ptr_q   <= ptr_q + 32'd4;
            state_q <= W_DAT;
          end
        end
        default: state_q <= W_IDLE;
      endcase
    end
  end

  // R1
  ptr_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (ptr_q[1:0] == 2'b00));
  // R6
  hdr_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == W_HDR) |-> (ptr_q < end_q));
  // R6
  ptr_forward_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !$past(start_i)) |-> (ptr_q >= $past(ptr_q)));
  // R10
  one_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);
  // R10
  rvalid_expected_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rvalid_i |-> (state_q == W_HDR_WAIT || state_q == W_DAT_WAIT));
endmodule

// File: rtl/cmdlist_proc.sv
module cmdlist_proc #(
  parameter int unsigned NUM_REGS = 64,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             host_we_i,
  input  logic [31:0]      host_addr_i,
  input  logic [31:0]      host_wdata_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [31:0]      rd_data_o,
  output logic             mem_rd_o,
  output logic [31:0]      mem_addr_o,
  input  logic [31:0]      mem_rdata_i,
  input  logic             mem_rvalid_i,
  output logic             busy_o
);
  import cmdlist_pkg::*;
  logic [NUM_REGS-1:0][31:0] regs;
  logic             host_hit, list_wr, list_ok, wr_en, fire, sel1;
  logic [IDX_W-1:0] host_idx, wr_idx;
  logic [15:0]      list_id;
  logic [31:0]      list_data, list_mask, wr_data, wr_mask;
  logic [31:0]      base_sel, size_sel, start_base, start_size;
  logic             unused_cfg;

  cmd_host_window #(.NUM_REGS(NUM_REGS)) u_win (
    .we_i(host_we_i), .addr_i(host_addr_i), .hit_o(host_hit), .idx_o(host_idx)
  );

  cmd_walker u_walk (
    .clk_i, .rst_ni,
    .start_i(fire), .start_base_i(start_base), .start_size_i(start_size),
    .mem_rd_o, .mem_addr_o, .mem_rdata_i, .mem_rvalid_i,
    .wr_en_o(list_wr), .wr_id_o(list_id), .wr_data_o(list_data),
    .wr_mask_o(list_mask), .busy_o
  );

  // list writes own the port while busy; host is shut out
  assign list_ok = list_wr && (list_id < 16'(NUM_REGS));
  assign wr_en   = list_ok || (host_hit && !busy_o);
  assign wr_idx  = list_wr ? list_id[IDX_W-1:0] : host_idx;
  assign wr_data = list_wr ? list_data : host_wdata_i;
  assign wr_mask = list_wr ? list_mask : 32'hFFFF_FFFF;

  cmd_regfile #(.NUM_REGS(NUM_REGS)) u_rf (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .wr_mask_i(wr_mask), .regs_o(regs)
  );

  assign sel1 = (wr_idx == IDX_W'(REG_TRIG1));
  assign fire = wr_en && (wr_data != '0) &&
                ((wr_idx == IDX_W'(REG_TRIG0)) || sel1);
  assign base_sel   = sel1 ? regs[REG_ADDR1] : regs[REG_ADDR0];
  assign size_sel   = sel1 ? regs[REG_SIZE1] : regs[REG_SIZE0];
  assign start_base = {1'b0, base_sel[27:0], 3'b000};
  assign start_size = {9'd0, size_sel[19:0], 3'b000};
  assign unused_cfg = ^{base_sel[31:28], size_sel[31:20]};
  assign rd_data_o  = regs[rd_idx_i];

  // R5
  trig_starts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && start_size != '0) |=> busy_o);
  // R9
  host_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !list_wr) |-> !wr_en);
endmodule

// File: tb/cmdlist_proc_bench.sv
module cmdlist_proc_bench;
  localparam int unsigned NR = 64;
  localparam logic [31:0] BASE = 32'h1EF0_1000;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_we = 1'b0;
  logic [31:0] host_addr = '0, host_wdata = '0;
  logic [5:0]  rd_idx = '0;
  logic [31:0] rd_data, mem_addr, mem_rdata = '0;
  logic        mem_rd, mem_rvalid = 1'b0, busy;
  logic [31:0] mem [128];
  int checks = 0, errors = 0, reads = 0, cyc = 0;

  always #10 clk = ~clk;

  cmdlist_proc #(.NUM_REGS(NR)) u_cmdlist_proc (
    .clk_i(clk), .rst_ni(rst_n), .host_we_i(host_we), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .mem_rvalid_i(mem_rvalid), .busy_o(busy)
  );

  always @(posedge clk) begin
    mem_rvalid <= mem_rd;
    mem_rdata  <= mem[mem_addr[8:2]];
    if (mem_rd) reads <= reads + 1;
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: got %0d cycles exp < 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] hdr(int id, int code, int cnt, bit step);
    return {step, 3'b000, 8'(cnt), 4'(code), 16'(id)};
  endfunction

  function automatic logic [31:0] lanes(int code);
    logic [31:0] m;
    for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{code[k]}};
    return m;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h exp %h", tag, act, exp);
    end
  endtask

  task automatic hwrite(logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rwrite(int idx, logic [31:0] d);
    hwrite(BASE + 32'(4 * idx), d);
  endtask

  task automatic rread(int idx, output logic [31:0] d);
    rd_idx = 6'(idx);
    #1 d = rd_data;
  endtask

  task automatic wait_idle(string tag);
    int n = 0;
    while (busy && n < 400) begin @(negedge clk); n++; end
    check(tag, {31'd0, busy}, 32'd0);
  endtask

  initial begin
    logic [31:0] v, r6;
    for (int i = 0; i < 128; i++) mem[i] = '0;
    // list A at word 32: single, stepping x3, odd fixed x2 + pad
    mem[32] = hdr(2, 15, 0, 1'b0); mem[33] = 32'h1111_2222;
    mem[34] = hdr(3, 15, 2, 1'b1);
    mem[35] = 32'h3000_0003; mem[36] = 32'h4000_0004; mem[37] = 32'h5000_0005;
    mem[38] = hdr(6, 5, 1, 1'b0); mem[39] = 32'h0102_0304; mem[40] = 32'hA0B0_C0D0;
    mem[41] = hdr(8, 15, 0, 1'b0);
    mem[42] = hdr(9, 15, 0, 1'b0); mem[43] = 32'hDEAD_0009;
    // list B at word 48: self trigger then a command that must not run
    mem[48] = hdr(20, 15, 0, 1'b0); mem[49] = 32'd1;
    mem[50] = hdr(11, 15, 0, 1'b0); mem[51] = 32'hBAD0_000B;
    mem[56] = hdr(10, 15, 0, 1'b0); mem[57] = 32'h0A0A_0A0A;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 reset state
    check("R6 busy after reset", {31'd0, busy}, 32'd0);
    rread(20, v); check("R8 reset value", v, 32'd0);

    // R8 window sweep over untouched indices
    for (int i = 22; i < NR; i++) rwrite(i, 32'(i) * 32'h0101_0101 ^ 32'h5A);
    for (int i = 22; i < NR; i++) begin
      rread(i, v); check("R8 window write", v, 32'(i) * 32'h0101_0101 ^ 32'h5A);
    end
    hwrite(BASE + 32'h0C00, 32'hFFFF_0001);
    hwrite(BASE + 32'(4 * NR), 32'hFFFF_0002);
    rread(0, v); check("R8 out of window/index", v, 32'd0);
    hwrite(BASE - 32'd4, 32'hFFFF_0003);
    rread(63, v); check("R8 below window", v, 32'(63) * 32'h0101_0101 ^ 32'h5A);

    // R5 zero trigger / zero size start nothing
    rwrite(21, 32'd0);
    check("R5 zero trigger", {31'd0, busy}, 32'd0);
    rwrite(21, 32'd1);
    check("R5 zero size", {31'd0, busy}, 32'd0);

    // list A
    r6 = 32'hAABB_CCDD;
    rwrite(6, r6);
    rwrite(16, 32'h80 >> 3);
    rwrite(18, 32'd5);
    reads = 0;
    rwrite(20, 32'd1);
    check("R5 busy after trigger", {31'd0, busy}, 32'd1);
    rwrite(12, 32'h0000_1234);
    wait_idle("R6 list A ends");
    rread(2, v);  check("R2 fixed single", v, 32'h1111_2222);
    rread(3, v);  check("R2 step id+0", v, 32'h3000_0003);
    rread(4, v);  check("R2 step id+1", v, 32'h4000_0004);
    rread(5, v);  check("R2 step id+2", v, 32'h5000_0005);
    rread(6, v);  check("R3 masked fixed target", v,
                        (r6 & ~lanes(5)) | (32'hA0B0_C0D0 & lanes(5)));
    rread(7, v);  check("R2 fixed no step", v, 32'(7) * 32'h0 );
    rread(8, v);  check("R4 pad skipped", v, 32'd0);
    rread(9, v);  check("R6 size stop", v, 32'd0);
    rread(12, v); check("R9 host ignored while busy", v, 32'd0);
    check("R10 read count", 32'(reads), 32'd9);

    // R7 self retrigger
    rwrite(16, 32'hE0 >> 3);
    rwrite(18, 32'd1);
    rwrite(17, 32'hC0 >> 3);
    rwrite(19, 32'd2);
    rwrite(21, 32'd1);
    wait_idle("R7 chained list ends");
    rread(10, v); check("R7 restart target run", v, 32'h0A0A_0A0A);
    rread(11, v); check("R7 remainder dropped", v, 32'd0);
    rread(20, v); check("R1 header id decode", v, 32'd1);

    // R3 exhaustive mask code sweep
    rwrite(16, 32'h100 >> 3);
    rwrite(18, 32'd1);
    for (int c = 0; c < 16; c++) begin
      mem[64] = hdr(30, c, 0, 1'b0);
      mem[65] = 32'h0;
      rwrite(30, 32'hA5A5_A5A5);
      rwrite(20, 32'd1);
      wait_idle("R6 mask list ends");
      rread(30, v); check("R3 mask code", v, 32'hA5A5_A5A5 & ~lanes(c));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule